// File: doc/BRIEF.md
# Address-Space Router with Byte Sequencing and Peripheral Registers

This block takes the load/store port of a 16-bit processor and serves it from a byte-organised 64 KiB address space. It sorts each address into one of three regions by the two top address bits: read-only program store, peripheral registers, or read/write data store. Every access is carried out as one or two byte cycles over an 8-bit datapath. A byte access takes one cycle. A word access takes two cycles, with the low-order byte at the given address and the high-order byte at the next address. The processor holds its request until `ready` comes back, and it stalls while `busy` is high.

The peripheral region holds three live registers. A free-running 8-bit tick counter restarts when it is read. A receive holding register captures each byte a serial receiver hands over and empties when it is read. A transmit register emits a byte toward a serial transmitter as a single-cycle strobe. The program store is filled through a separate load port before the processor runs. The two stores are built at a parameterised size and repeat over their region, so only the low address bits index them.

Top module: `memmap_ctrl`

## Requirements
- R1: The region follows address bits [15:14]: 00 selects the program store, 01 the peripheral registers, and 1x the data store. Within a store only the low ROM_AW or RAM_AW address bits index it, so the contents repeat across the region.
- R2: A byte access (`is_word`=0) completes in the cycle it is requested, with `ready`=1 and `busy`=0. A word access shows `busy`=1 and `ready`=0 in its first cycle and `ready`=1 in its second. With no request, both are 0.
- R3: A word is little-endian. `rdata[7:0]` comes from the addressed byte and `rdata[15:8]` from address+1, which wraps modulo 2^16 and may fall in another region. A word write places `wdata[7:0]` at the address and `wdata[15:8]` at address+1.
- R4: A byte read returns the byte on `rdata[7:0]`, and `rdata[15:8]` is 0.
- R5: A byte write stores only `wdata[7:0]` and leaves the neighbouring byte unchanged.
- R6: Processor writes into the program-store region change nothing. The store is written only through `rom_ld_en`/`rom_ld_addr`/`rom_ld_data`.
- R7: The tick register at 0x4000 gains 1 on every clock edge and wraps at 256. A read returns its present value, and on the edge that completes that byte cycle the register becomes 1. After a read followed by N idle edges, the next read returns (1+N) mod 256.
- R8: The receive register at 0x4100 loads `rx_byte` on each edge where `rx_valid`=1. A read returns its value and clears it to 0. If a byte arrives on the same edge as a read, the read returns the old value and the register keeps the new byte.
- R9: Each byte cycle that writes address 0x4102 raises `tx_valid` for exactly one cycle, on the cycle after it, with that byte on `tx_byte`. The byte is the high byte of `wdata` when 0x4102 is the second cycle of a word write.
- R10: Every other peripheral address reads as 0 and ignores writes. Writes to 0x4000 and 0x4100 also change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until ready |
| we | input | 1 | 1 = write, 0 = read |
| is_word | input | 1 | 1 = 16-bit access, 0 = 8-bit |
| addr | input | 16 | Byte address |
| wdata | input | 16 | Write data |
| ready | output | 1 | Access completes on this cycle's edge |
| busy | output | 1 | Request pending, processor must stall |
| rdata | output | 16 | Read data, valid while ready is high |
| rx_valid | input | 1 | Serial receiver delivers a byte |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_byte | output | 8 | Byte to transmit |
| rom_ld_en | input | 1 | Program-store load strobe |
| rom_ld_addr | input | ROM_AW | Program-store load index |
| rom_ld_data | input | 8 | Program-store load byte |

## Verification
The program store is filled with an arithmetic pattern, and a word read is made at every one of its byte addresses. This separates a correct little-endian pairing from swapped or unincremented high bytes, and it exposes wrong aliasing at the top index. The data store is filled by word writes and then read back both byte-wise and as odd-aligned words. Separate probes check the top-of-space wrap into the program store, byte-write isolation and ignored program-store writes. For the tick register, the reads are separated by idle gaps of increasing length, up to a gap that makes the counter wrap, so the reload-to-one value and the count rate are both pinned down. The receive and transmit registers are tested with arrivals that coincide with reads and with word accesses that reach them in their second byte cycle.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  typedef enum logic [1:0] {RG_ROM = 2'd0, RG_MMIO = 2'd1, RG_RAM = 2'd2} region_e;

  localparam logic [15:0] TICK_ADDR = 16'h4000;
  localparam logic [15:0] RXB_ADDR  = 16'h4100;
  localparam logic [15:0] TXB_ADDR  = 16'h4102;

  // region from the two top address bits
  function automatic region_e region_of(input logic [15:0] a);
    if (a[15])      return RG_RAM;
    else if (a[14]) return RG_MMIO;
    else            return RG_ROM;
  endfunction

  // address of the byte handled in the first (0) or second (1) byte cycle
  function automatic logic [15:0] lane_addr(input logic [15:0] base, input logic second);
    return base + {15'd0, second};
  endfunction

  // next tick value: reload to one on a clearing read, otherwise count up
  function automatic logic [7:0] tick_next(input logic [7:0] cur, input logic clr);
    return clr ? 8'd1 : cur + 8'd1;
  endfunction
endpackage

// File: rtl/mm_decode.sv
module mm_decode
  import memmap_pkg::*;
(
  input  logic [15:0] a,
  output region_e     rg,
  output logic        sel_tick,
  output logic        sel_rx,
  output logic        sel_tx
);
  always_comb begin
    rg       = region_of(a);
    sel_tick = (a == TICK_ADDR);
    sel_rx   = (a == RXB_ADDR);
    sel_tx   = (a == TXB_ADDR);
  end
endmodule

// File: rtl/mm_bytemem.sv
module mm_bytemem #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [7:0]    wr_byte,
  input  logic [AW-1:0] rd_idx,
  output logic [7:0]    rd_byte
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_idx] <= wr_byte;
  end

  assign rd_byte = cells[rd_idx];
endmodule

// File: rtl/mm_periph.sv
module mm_periph
  import memmap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_tick,
  input  logic       rd_rx,
  input  logic       wr_tx,
  input  logic [7:0] wbyte,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic [7:0] tick_q,
  output logic [7:0] rx_q,
  output logic       tx_valid,
  output logic [7:0] tx_byte
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q   <= 8'd0;
      rx_q     <= 8'd0;
      tx_valid <= 1'b0;
      tx_byte  <= 8'd0;
    end else begin
      tick_q <= tick_next(tick_q, rd_tick);
      if (rx_valid)   rx_q <= rx_byte;
      else if (rd_rx) rx_q <= 8'd0;
      tx_valid <= wr_tx;
      if (wr_tx) tx_byte <= wbyte;
    end
  end
endmodule

// File: rtl/memmap_ctrl.sv
module memmap_ctrl
  import memmap_pkg::*;
#(
  parameter int ROM_AW = 8,
  parameter int RAM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic              is_word,
  input  logic [15:0]       addr,
  input  logic [15:0]       wdata,
  output logic              ready,
  output logic              busy,
  output logic [15:0]       rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              rom_ld_en,
  input  logic [ROM_AW-1:0] rom_ld_addr,
  input  logic [7:0]        rom_ld_data
);
  typedef enum logic {PH_FIRST = 1'b0, PH_SECOND = 1'b1} phase_e;

  phase_e      phase_q;
  logic        second;
  logic [15:0] cyc_addr;
  logic [7:0]  cyc_wbyte;
  logic [7:0]  cyc_rbyte;
  logic [7:0]  lo_q;
  region_e     cyc_rg;
  logic        sel_tick, sel_rx, sel_tx;
  logic [7:0]  rom_byte, ram_byte, io_byte;
  logic [7:0]  tick_q, rx_q;
  logic        cyc_rd, cyc_wr;

  assign second    = (phase_q == PH_SECOND);
  assign cyc_addr  = lane_addr(addr, second);
  assign cyc_wbyte = second ? wdata[15:8] : wdata[7:0];
  assign cyc_rd    = req && !we;
  assign cyc_wr    = req && we;

  mm_decode u_dec (
    .a(cyc_addr), .rg(cyc_rg), .sel_tick(sel_tick), .sel_rx(sel_rx), .sel_tx(sel_tx)
  );

  mm_bytemem #(.AW(ROM_AW)) u_rom (
    .clk(clk), .wr_en(rom_ld_en), .wr_idx(rom_ld_addr), .wr_byte(rom_ld_data),
    .rd_idx(cyc_addr[ROM_AW-1:0]), .rd_byte(rom_byte)
  );

  mm_bytemem #(.AW(RAM_AW)) u_ram (
    .clk(clk), .wr_en(cyc_wr && (cyc_rg == RG_RAM)), .wr_idx(cyc_addr[RAM_AW-1:0]),
    .wr_byte(cyc_wbyte), .rd_idx(cyc_addr[RAM_AW-1:0]), .rd_byte(ram_byte)
  );

  mm_periph u_io (
    .clk(clk), .rst_n(rst_n),
    .rd_tick(cyc_rd && sel_tick), .rd_rx(cyc_rd && sel_rx), .wr_tx(cyc_wr && sel_tx),
    .wbyte(cyc_wbyte), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tick_q(tick_q), .rx_q(rx_q), .tx_valid(tx_valid), .tx_byte(tx_byte)
  );

  always_comb begin
    if (sel_tick)    io_byte = tick_q;
    else if (sel_rx) io_byte = rx_q;
    else             io_byte = 8'd0;
    unique case (cyc_rg)
      RG_ROM:  cyc_rbyte = rom_byte;
      RG_MMIO: cyc_rbyte = io_byte;
      default: cyc_rbyte = ram_byte;
    endcase
  end

  assign ready = req && (!is_word || second);
  assign busy  = req && !ready;

  always_comb begin
    if (!ready)       rdata = 16'd0;
    else if (is_word) rdata = {cyc_rbyte, lo_q};
    else              rdata = {8'd0, cyc_rbyte};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FIRST;
      lo_q    <= 8'd0;
    end else begin
      if (req && is_word && !second) begin
        phase_q <= PH_SECOND;
        lo_q    <= cyc_rbyte;
      end else begin
        phase_q <= PH_FIRST;
      end
    end
  end
endmodule

// File: rtl/memmap_ctrl_chk.sv
module memmap_ctrl_chk
  import memmap_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        we,
  input logic        is_word,
  input logic        ready,
  input logic        busy,
  input logic [15:0] rdata,
  input logic        rx_valid,
  input logic        tx_valid,
  input logic [7:0]  tx_byte,
  input logic [15:0] cyc_addr,
  input logic [7:0]  cyc_wbyte,
  input logic [7:0]  tick_q,
  input logic [7:0]  rx_q
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_BYTE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !is_word) |-> (ready && !busy)); // R2
  AST_WORD_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (req && is_word && ready) |-> $past(req && is_word && busy)); // R2
  AST_BYTE_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !is_word && !we) |-> (rdata[15:8] == 8'd0)); // R4
  AST_TICK_RATE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(req && !we && cyc_addr == TICK_ADDR) |-> (tick_q == 8'($past(tick_q) + 8'd1))); // R7
  AST_TICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && cyc_addr == TICK_ADDR) |=> (tick_q == 8'd1)); // R7
  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && cyc_addr == RXB_ADDR && !rx_valid) |=> (rx_q == 8'd0)); // R8
  AST_TX_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    tx_valid |-> ($past(req && we && cyc_addr == TXB_ADDR) && tx_byte == $past(cyc_wbyte))); // R9
endmodule

bind memmap_ctrl memmap_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .is_word(is_word), .ready(ready),
  .busy(busy), .rdata(rdata), .rx_valid(rx_valid), .tx_valid(tx_valid), .tx_byte(tx_byte),
  .cyc_addr(cyc_addr), .cyc_wbyte(cyc_wbyte), .tick_q(tick_q), .rx_q(rx_q)
);

// File: tb/memmap_ctrl_tb.sv
module memmap_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, is_word = 1'b0;
  logic [15:0] addr = 16'd0, wdata = 16'd0;
  logic ready, busy, tx_valid;
  logic [15:0] rdata;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'd0, tx_byte;
  logic rom_ld_en = 1'b0;
  logic [AW-1:0] rom_ld_addr = '0;
  logic [7:0] rom_ld_data = 8'd0;

  int n_chk = 0, n_bad = 0;
  int tx_cnt = 0;
  logic [7:0] tx_last = 8'd0;
  logic [7:0] ram_m [256];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memmap_ctrl #(.ROM_AW(AW), .RAM_AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .is_word(is_word), .addr(addr),
    .wdata(wdata), .ready(ready), .busy(busy), .rdata(rdata), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_valid(tx_valid), .tx_byte(tx_byte), .rom_ld_en(rom_ld_en),
    .rom_ld_addr(rom_ld_addr), .rom_ld_data(rom_ld_data)
  );

  always @(posedge clk) if (tx_valid) begin tx_cnt++; tx_last = tx_byte; end

  function automatic logic [7:0] romf(input int i);
    return 8'((i % 256) * 37 + 11);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic acc(input bit w, input bit wd, input logic [15:0] a, input logic [15:0] d,
                     input bit rxv, input logic [7:0] rxb,
                     output logic [15:0] q, output int lat);
    @(negedge clk);
    req = 1'b1; we = w; is_word = wd; addr = a; wdata = d;
    rx_valid = rxv; rx_byte = rxb;
    lat = 0;
    while (1) begin
      #1;
      lat++;
      if (ready || lat > 4) break;
      @(negedge clk);
    end
    q = rdata;
    @(posedge clk);
    #1 req = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic rd(input bit wd, input logic [15:0] a, output logic [15:0] q, output int lat);
    acc(1'b0, wd, a, 16'd0, 1'b0, 8'd0, q, lat);
  endtask

  task automatic wr(input bit wd, input logic [15:0] a, input logic [15:0] d);
    logic [15:0] q; int lat;
    acc(1'b1, wd, a, d, 1'b0, 8'd0, q, lat);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] q, e; int lat, c0;
    repeat (3) @(posedge clk);
    #1;
    chk(!ready && !busy && !tx_valid, "R2 reset idle", {13'd0, ready, busy, tx_valid}, 16'd0);
    // preload program store
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); rom_ld_en = 1'b1; rom_ld_addr = AW'(i); rom_ld_data = romf(i);
    end
    @(negedge clk); rom_ld_en = 1'b0;
    rst_n = 1'b1;
    rd(1'b0, 16'h4100, q, lat);
    chk(q == 16'd0, "R8 rx empty after reset", q, 16'd0);

    // R3 R1: word reads over the whole program store
    for (int i = 0; i < 256; i++) begin
      rd(1'b1, 16'(i), q, lat);
      e = {romf(i + 1), romf(i)};
      chk(q == e && lat == 2, "R3 rom word", q, e);
    end
    rd(1'b0, 16'h3F05, q, lat);
    chk(q == {8'd0, romf(5)}, "R1 rom alias", q, {8'd0, romf(5)});

    // R6: writes into program store are dropped
    wr(1'b0, 16'h0005, 16'h00FF);
    wr(1'b1, 16'h0010, 16'hDEAD);
    rd(1'b0, 16'h0005, q, lat);
    chk(q == {8'd0, romf(5)}, "R6 rom byte write ignored", q, {8'd0, romf(5)});
    rd(1'b1, 16'h0010, q, lat);
    chk(q == {romf(17), romf(16)}, "R6 rom word write ignored", q, {romf(17), romf(16)});

    // R3 R5: fill data store by words, read back
    for (int i = 0; i < 128; i++) begin
      e = 16'(i * 16'h0123) ^ 16'h5A5A;
      ram_m[2*i] = e[7:0]; ram_m[2*i+1] = e[15:8];
      wr(1'b1, 16'h8000 + 16'(2*i), e);
    end
    for (int i = 0; i < 256; i++) begin
      rd(1'b0, 16'h8000 + 16'(i), q, lat);
      chk(q == {8'd0, ram_m[i]} && lat == 1, "R4 ram byte read", q, {8'd0, ram_m[i]});
    end
    for (int i = 1; i < 256; i += 2) begin
      rd(1'b1, 16'h8000 + 16'(i), q, lat);
      e = {ram_m[(i + 1) % 256], ram_m[i]};
      chk(q == e, "R3 ram odd word", q, e);
    end
    rd(1'b0, 16'hC033, q, lat);
    chk(q == {8'd0, ram_m[8'h33]}, "R1 ram alias", q, {8'd0, ram_m[8'h33]});
    rd(1'b1, 16'hFFFF, q, lat);
    chk(q == {romf(0), ram_m[255]}, "R3 wrap to rom", q, {romf(0), ram_m[255]});

    // R5: byte store keeps the neighbour
    wr(1'b1, 16'h8010, 16'h1234);
    wr(1'b0, 16'h8011, 16'hBEEF);
    rd(1'b1, 16'h8010, q, lat);
    chk(q == 16'hEF34, "R5 byte store low only", q, 16'hEF34);

    // R7: tick counter over several idle gaps
    foreach (ram_m[k]) if (k < 0) ram_m[k] = 8'd0;
    rd(1'b0, 16'h4000, q, lat);
    for (int g = 0; g < 5; g++) begin
      int n;
      n = (g == 0) ? 0 : (g == 1) ? 1 : (g == 2) ? 5 : (g == 3) ? 40 : 300;
      repeat (n) @(posedge clk);
      rd(1'b0, 16'h4000, q, lat);
      e = {8'd0, 8'(1 + n)};
      chk(q == e, "R7 tick after gap", q, e);
    end
    repeat (9) @(posedge clk);
    rd(1'b1, 16'h4000, q, lat);
    chk(q == 16'd10, "R7 tick word read", q, 16'd10);

    // R8: receive register
    @(negedge clk); rx_valid = 1'b1; rx_byte = 8'hC3;
    @(negedge clk); rx_valid = 1'b0;
    rd(1'b0, 16'h4100, q, lat);
    chk(q == 16'h00C3, "R8 rx read", q, 16'h00C3);
    rd(1'b0, 16'h4100, q, lat);
    chk(q == 16'h0000, "R8 rx cleared", q, 16'h0000);
    @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h11;
    @(negedge clk); rx_valid = 1'b0;
    acc(1'b0, 1'b0, 16'h4100, 16'd0, 1'b1, 8'h22, q, lat);
    chk(q == 16'h0011, "R8 coincident read old", q, 16'h0011);
    rd(1'b0, 16'h4100, q, lat);
    chk(q == 16'h0022, "R8 coincident arrival kept", q, 16'h0022);
    @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h5E;
    @(negedge clk); rx_valid = 1'b0;
    rd(1'b1, 16'h40FF, q, lat);
    chk(q == 16'h5E00, "R8 rx in word high byte", q, 16'h5E00);

    // R9: transmit strobe
    c0 = tx_cnt;
    wr(1'b0, 16'h4102, 16'h775A);
    repeat (3) @(posedge clk); #1;
    chk(tx_cnt == c0 + 1 && tx_last == 8'h5A, "R9 tx byte write", {8'(tx_cnt - c0), tx_last}, 16'h015A);
    c0 = tx_cnt;
    wr(1'b1, 16'h4101, 16'hA533);
    repeat (3) @(posedge clk); #1;
    chk(tx_cnt == c0 + 1 && tx_last == 8'hA5, "R9 tx word second lane", {8'(tx_cnt - c0), tx_last}, 16'h01A5);
    c0 = tx_cnt;
    wr(1'b1, 16'h4102, 16'h1234);
    wr(1'b0, 16'h4102, 16'h0099);
    repeat (3) @(posedge clk); #1;
    chk(tx_cnt == c0 + 2 && tx_last == 8'h99, "R9 tx two pulses", {8'(tx_cnt - c0), tx_last}, 16'h0299);

    // R10: unused peripheral addresses and read-only registers
    rd(1'b0, 16'h4001, q, lat);
    chk(q == 16'd0, "R10 unused byte", q, 16'd0);
    rd(1'b1, 16'h4200, q, lat);
    chk(q == 16'd0, "R10 unused word", q, 16'd0);
    c0 = tx_cnt;
    wr(1'b1, 16'h7FFE, 16'hFFFF);
    wr(1'b0, 16'h4100, 16'h0077);
    repeat (3) @(posedge clk); #1;
    chk(tx_cnt == c0, "R10 no stray tx", 16'(tx_cnt - c0), 16'd0);
    rd(1'b0, 16'h4100, q, lat);
    chk(q == 16'd0, "R10 rx write ignored", q, 16'd0);
    rd(1'b0, 16'h4000, q, lat);
    wr(1'b0, 16'h4000, 16'h0080);
    rd(1'b0, 16'h4000, q, lat);
    chk(q == 16'd2, "R10 tick write ignored", q, 16'd2);

    finish_run();
  end
endmodule